// File: doc/BRIEF.md
# Hexadecimal Dot-Matrix Digit Scanner

This block drives a six-position LED readout in which every position is a hand-built grid of 20 LEDs arranged four dots wide and five dots tall. A bus-side agent writes a 4-bit hex value into one of six per-position holding registers by raising a write strobe together with a position number. The block then scans the positions one at a time. A one-hot rotating register selects the active position, and an OR-multiplexer picks that position's stored nibble. A fixed glyph table turns the nibble into the 20-bit dot pattern placed on the shared dot lines.

One enable output exists per position, and it drives that position's current-sink transistor. The dot lines are common to all positions. The enable vector and the dot pattern are registered together, so they always change on the same edge. One all-dark cycle separates every change of position, which stops a dim ghost of one glyph from appearing on the next position. A prescaler sets the scan rate: each position is lit for `TICK_DIV-1` cycles and then blanked for one cycle.

Top module: `hex_matrix_scanner`

## Requirements
- R1: While `rst_n` is low, `dig_en` and `rows` are all zero and every holding register is cleared to 0. The first clock edge after release shows position 0 with the glyph of value 0.
- R2: In every cycle, at most one bit of `dig_en` is high.
- R3: Bit d of `dig_en` enables position d. Counting edges from n=1 after reset, position ((n-1)/TICK_DIV) mod 6 is lit, except on edges where (n-1) mod TICK_DIV equals TICK_DIV-1. Positions therefore advance 0,1,2,3,4,5 and then wrap to 0.
- R4: On each cycle where (n-1) mod TICK_DIV equals TICK_DIV-1, both `dig_en` and `rows` are all zero. Whenever `dig_en` is zero, `rows` is zero. Two different positions are never lit on consecutive cycles.
- R5: While position d is lit, `rows` carries the glyph of the value held for position d. This value is the one that was stored before the edge that produced the output.
- R6: Glyphs are five hex digits, with the top dot row first and the MSB of each hex digit as the leftmost dot (`rows[19]` is top-left): 0=69996, 1=26227, 2=E168F, 3=E161E, 4=99F11, 5=F8E1E, 6=68E96, 7=F1244, 8=69696, 9=69716, A=69F99, B=E9E9E, C=78887, D=E999E, E=F8E8F, F=F8E88.
- R7: A clock edge with `load` high and `load_idx` below 6 stores `load_val` for that position. The output register uses the new value from the following edge onward.
- R8: A load with `load_idx` equal to 6 or 7 changes no stored value.
- R9: Loads, including a load to the lit position on the cycle before a blank, never shift the scan timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Write strobe for one holding register |
| load_idx | input | 3 | Position number to write (0 to 5 valid) |
| load_val | input | 4 | Hex value to store |
| dig_en | output | 6 | One-hot position enable, bit d drives position d |
| rows | output | 20 | Shared dot lines, one bit per LED of the lit glyph |

## Verification
A write and a change of position can land on the same edge. This happens when the strobe targets the position that is lit during the last cycle before a blank, or the position that lights up right after it. The bench provokes this by holding the strobe high for many consecutive cycles while cycling the position number. Its scoreboard derives every expected output from the edge count and its own copy of the stored values. Any slip in timing or any stale glyph shows up on a specific edge.

// File: rtl/hex_matrix_scanner.sv
module hex_matrix_scanner #(
  parameter int DIGITS   = 6,
  parameter int TICK_DIV = 4,
  localparam int IDXW    = $clog2(DIGITS),
  localparam int DOTS    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDXW-1:0]   load_idx,
  input  logic [3:0]        load_val,
  output logic [DIGITS-1:0] dig_en,
  output logic [DOTS-1:0]   rows
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0]       pre_q;
  logic [DIGITS-1:0]   ring_q;
  logic [4*DIGITS-1:0] latch_q;
  logic [3:0]          cur_nib;
  logic                tick;
  logic                ring_ok;

  assign tick    = (pre_q == LAST);
  assign ring_ok = (ring_q != '0) && ((ring_q & (ring_q - 1'b1)) == '0);

  function automatic logic [DOTS-1:0] glyph(input logic [3:0] v);
    case (v)
      4'h0: return 20'h69996;
      4'h1: return 20'h26227;
      4'h2: return 20'hE168F;
      4'h3: return 20'hE161E;
      4'h4: return 20'h99F11;
      4'h5: return 20'hF8E1E;
      4'h6: return 20'h68E96;
      4'h7: return 20'hF1244;
      4'h8: return 20'h69696;
      4'h9: return 20'h69716;
      4'hA: return 20'h69F99;
      4'hB: return 20'hE9E9E;
      4'hC: return 20'h78887;
      4'hD: return 20'hE999E;
      4'hE: return 20'hF8E8F;
      default: return 20'hF8E88;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ring_q <= DIGITS'(1);
    else if (!ring_ok) ring_q <= DIGITS'(1);
    else if (tick)     ring_q <= {ring_q[DIGITS-2:0], ring_q[DIGITS-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) latch_q <= '0;
    else if (load)
      for (int d = 0; d < DIGITS; d++)
        if (load_idx == IDXW'(d)) latch_q[d*4 +: 4] <= load_val;

  always_comb begin
    cur_nib = '0;
    for (int d = 0; d < DIGITS; d++)
      if (ring_q[d]) cur_nib = cur_nib | latch_q[d*4 +: 4];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dig_en <= '0;
      rows   <= '0;
    end else if (tick || !ring_ok) begin
      dig_en <= '0;
      rows   <= '0;
    end else begin
      dig_en <= ring_q;
      rows   <= glyph(cur_nib);
    end
endmodule

// File: rtl/hex_matrix_scanner_chk.sv
module hex_matrix_scanner_chk #(
  parameter int DIGITS = 6,
  parameter int IDXW   = 3,
  parameter int DOTS   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [IDXW-1:0]   load_idx,
  input logic [3:0]        load_val,
  input logic [DIGITS-1:0] dig_en,
  input logic [DOTS-1:0]   rows,
  input logic [4*DIGITS-1:0] latch_q
);
  logic [DIGITS-1:0] last_on;
  logic              ld_q;
  logic [IDXW-1:0]   idx_q;
  logic [3:0]        val_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      last_on <= '0;
      ld_q    <= 1'b0;
      idx_q   <= '0;
      val_q   <= '0;
    end else begin
      if (dig_en != '0) last_on <= dig_en;
      ld_q  <= load;
      idx_q <= load_idx;
      val_q <= load_val;
    end

  a_r2_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_en));

  a_r4_dark_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en == '0) |-> (rows == '0));

  a_r4_gap_between: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dig_en) != '0 && dig_en != '0) |-> (dig_en == $past(dig_en)));

  a_r3_next_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en != '0 && $past(dig_en) == '0 && last_on != '0)
      |-> (dig_en == {last_on[DIGITS-2:0], last_on[DIGITS-1]}));

  a_r7_store: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && idx_q < DIGITS) |-> (latch_q[idx_q*4 +: 4] == val_q));

  a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_idx >= DIGITS) |=> $stable(latch_q));
endmodule

bind hex_matrix_scanner hex_matrix_scanner_chk #(
  .DIGITS(DIGITS), .IDXW(IDXW), .DOTS(DOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_idx(load_idx),
  .load_val(load_val), .dig_en(dig_en), .rows(rows), .latch_q(latch_q)
);

// File: tb/hex_matrix_scanner_test.sv
module hex_matrix_scanner_test;
  localparam int DIG = 6;
  localparam int TD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [2:0]  load_idx = '0;
  logic [3:0]  load_val = '0;
  logic [5:0]  dig_en;
  logic [19:0] rows;

  int checks = 0;
  int errors = 0;
  int unsigned edges = 0;
  logic [19:0] gtab [16];
  logic [3:0]  mnib [DIG];

  typedef struct packed { logic [5:0] en; logic [19:0] rw; } item_t;
  item_t q[$];

  hex_matrix_scanner #(.DIGITS(DIG), .TICK_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_idx(load_idx),
    .load_val(load_val), .dig_en(dig_en), .rows(rows));

  always #5 clk = ~clk;

  initial begin
    gtab[0]  = 20'h69996; gtab[1]  = 20'h26227; gtab[2]  = 20'hE168F; gtab[3]  = 20'hE161E;
    gtab[4]  = 20'h99F11; gtab[5]  = 20'hF8E1E; gtab[6]  = 20'h68E96; gtab[7]  = 20'hF1244;
    gtab[8]  = 20'h69696; gtab[9]  = 20'h69716; gtab[10] = 20'h69F99; gtab[11] = 20'hE9E9E;
    gtab[12] = 20'h78887; gtab[13] = 20'hE999E; gtab[14] = 20'hF8E8F; gtab[15] = 20'hF8E88;
    for (int d = 0; d < DIG; d++) mnib[d] = '0;
  end

  // Driver side of the scoreboard: expected item per edge (R3, R4, R5, R7, R9)
  always @(posedge clk) begin
    if (rst_n) begin
      int unsigned ph, dd;
      item_t it;
      edges = edges + 1;
      ph = (edges - 1) % TD;
      dd = ((edges - 1) / TD) % DIG;
      if (ph == TD - 1) it = '0;
      else begin
        it.en = 6'(1) << dd;
        it.rw = gtab[mnib[dd]];
      end
      q.push_back(it);
      if (load && load_idx < DIG) mnib[load_idx] <= load_val;
    end
  end

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if ($countones(dig_en) > 1) begin
        errors++; $display("FAIL R2: dig_en=%b expected at most one bit", dig_en);
      end
      checks++;
      if (dig_en !== e.en) begin
        errors++; $display("FAIL R3: dig_en=%b expected %b (edge %0d)", dig_en, e.en, edges);
      end
      checks++;
      if (rows !== e.rw) begin
        errors++;
        if (e.en == '0) $display("FAIL R4: rows=%h expected %h in blank cycle", rows, e.rw);
        else            $display("FAIL R5: rows=%h expected %h for en=%b", rows, e.rw, e.en);
      end
    end
  end

  task automatic put(input logic [2:0] i, input logic [3:0] v);
    @(negedge clk);
    load = 1'b1; load_idx = i; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1 rst_n = 1'b0;
    q.delete();
    edges = 0;
    for (int d = 0; d < DIG; d++) mnib[d] = '0;
    @(negedge clk);
    checks++;
    if (dig_en !== '0 || rows !== '0) begin   // R1
      errors++; $display("FAIL R1: dig_en=%b rows=%h expected 0 and 0", dig_en, rows);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic probe_glyph(input logic [3:0] v);   // R6
    put(3'd0, v);
    repeat (2 * DIG * TD) @(negedge clk);
    while (dig_en !== 6'b000001) @(negedge clk);
    checks++;
    if (rows !== gtab[v]) begin
      errors++; $display("FAIL R6: value %h rows=%h expected %h", v, rows, gtab[v]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dig_en !== '0 || rows !== '0) begin   // R1
      errors++; $display("FAIL R1: dig_en=%b rows=%h expected 0 and 0", dig_en, rows);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dig_en !== 6'b000001 || rows !== gtab[0]) begin   // R1 first frame
      errors++; $display("FAIL R1: first frame %b/%h expected 000001/%h", dig_en, rows, gtab[0]);
    end
    repeat (2 * DIG * TD) @(negedge clk);

    // R7: fill every position
    put(3'd0, 4'h1); put(3'd1, 4'hA); put(3'd2, 4'h3);
    put(3'd3, 4'hC); put(3'd4, 4'h5); put(3'd5, 4'hF);
    repeat (2 * DIG * TD) @(negedge clk);

    // R8: out-of-range positions
    put(3'd6, 4'h7); put(3'd7, 4'h8);
    repeat (2 * DIG * TD) @(negedge clk);

    // R6: every glyph on every position
    for (int v = 0; v < 16; v++) begin
      for (int d = 0; d < DIG; d++) put(3'(d), 4'((v + d) % 16));
      repeat (DIG * TD + 2) @(negedge clk);
    end
    for (int v = 0; v < 16; v++) probe_glyph(4'(v));

    // R9: strobe every cycle, colliding with blank and position changes
    @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      load = 1'b1;
      load_idx = 3'((k * 5 + k / 7) % 8);
      load_val = 4'((k * 3 + 1) % 16);
      @(negedge clk);
    end
    load = 1'b0;
    repeat (2 * DIG * TD) @(negedge clk);

    // R1: reset in mid-run clears stored values
    do_reset();
    repeat (2 * DIG * TD) @(negedge clk);
    put(3'd2, 4'h9);
    repeat (3 * DIG * TD) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule